// File: doc/BRIEF.md
# Strobed Serial Converter Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a three-wire serial link: a convert strobe driven by the host, a serial clock driven by the host, and one serial data line driven back by the converter. Each cycle starts when a request arrives or when an internal rate timer fires. The block raises the convert strobe, which samples the analog input and starts a conversion that runs on the converter's own clock. The converter gives no completion signal, so the block holds the strobe high for a fixed number of system clocks. It then drops the strobe, which enables the converter's data output with the most significant bit already present.

The controller waits out the output-enable delay and captures that first bit. It then issues fifteen serial clock pulses. The converter advances its data line on each falling edge, and the controller samples each new bit at the end of the low phase that follows. The sixteen bits, most significant first and in straight binary, are presented as one registered word with a one-cycle valid strobe. A minimum spacing between convert rising edges limits the throughput. Every time interval is a clock-count parameter.

Top module: `sar_serial_reader`

## Requirements
- R1: While reset is high and on the first cycle after it, adc_cnv, adc_sclk, busy and result_valid are 0 and result is 0. This holds even if reset arrives in the middle of a conversion.
- R2: Each time adc_cnv is raised, it stays high for exactly CONV_CYC clock cycles.
- R3: adc_sclk is never high while adc_cnv is high. After adc_cnv falls, adc_sclk stays low for exactly EN_CYC cycles, and adc_sdo is captured as bit 15 at the end of that wait.
- R4: Each conversion produces exactly DATA_W-1 falling edges on adc_sclk. Every high phase and every low phase lasts SCK_HALF cycles.
- R5: result holds the DATA_W captured bits. The first captured bit is bit 15 (the MSB), and each later bit fills the next lower position. The value is unsigned straight binary and comes from the conversion just finished.
- R6: result_valid is high for exactly one cycle per conversion, and result changes only in the cycle where result_valid is high.
- R7: busy is high from the cycle adc_cnv rises until the cycle before result_valid, and it is low while result_valid is high.
- R8: Two rising edges of adc_cnv are never closer than CYC_MIN cycles. When a request is already waiting, the next rising edge comes exactly CYC_MIN cycles after the previous one.
- R9: A request that arrives while a conversion is in progress is kept and starts exactly one more conversion. That later conversion still has its full strobe width and its full serial clock count.
- R10: While auto_en is high, the rate timer starts a conversion every AUTO_PERIOD cycles (with AUTO_PERIOD >= CYC_MIN), so the gap between successive rising edges of adc_cnv is exactly AUTO_PERIOD.
- R11: If the block is idle and the spacing limit is met, adc_cnv rises on the clock edge after the edge that samples start_req high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Single-cycle request to start one conversion |
| auto_en | input | 1 | Starts conversions from the internal rate timer |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert strobe to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idle low |
| result | output | DATA_W | Most recent conversion word |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| busy | output | 1 | High from the convert strobe rising until the result strobe |

## Verification
adc_cnv goes high one cycle after start_req is sampled, so the bench checks it one cycle after that sampling edge and confirms it is still low in between. From that rising edge, the strobe falls CONV_CYC cycles later, the first serial clock rises EN_CYC cycles after the fall, and result_valid arrives CONV_CYC + EN_CYC + 2*SCK_HALF*(DATA_W-1) cycles after the rise. A monitor that samples at mid-cycle counts these spans on the pins and compares each one with the value computed from the parameters. It also measures the spacing between strobe rises against CYC_MIN or AUTO_PERIOD. The converter model latches a word on each rising edge of the strobe and shifts it out on the falling serial clock edges. The expected result is therefore the word latched at the rising edge of the same conversion.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_ENW,
    ST_SCKH,
    ST_SCKL
  } rd_state_e;

  // bits needed to hold the value n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_rd_rate.sv
module sar_rd_rate
  import sar_rd_pkg::*;
#(
  parameter int unsigned CYC_MIN     = 1000,
  parameter int unsigned AUTO_PERIOD = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic auto_en,
  input  logic seq_idle,
  output logic launch,
  output logic spacing_ok
);
  localparam int unsigned SP_W = cnt_bits(CYC_MIN);
  localparam int unsigned AT_W = cnt_bits(AUTO_PERIOD);
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(CYC_MIN);
  localparam logic [AT_W-1:0] AT_LAST = AT_W'(AUTO_PERIOD - 1);

  logic [SP_W-1:0] since_q;
  logic [AT_W-1:0] at_q;
  logic            pend_q;
  logic            tick;

  assign spacing_ok = (since_q == SP_FULL);
  assign tick       = auto_en && (at_q == AT_LAST);
  assign launch     = pend_q && spacing_ok && seq_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= SP_FULL;
      at_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (launch)          since_q <= SP_W'(1);
      else if (!spacing_ok) since_q <= since_q + SP_W'(1);

      if (!auto_en || tick) at_q <= '0;
      else                  at_q <= at_q + AT_W'(1);

      pend_q <= (pend_q && !launch) || start_req || tick;
    end
  end

  // R9: a waiting request is dropped only by starting a conversion
  p_pend_held_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !launch) |=> pend_q);

  // R8: spacing restarts from one after every launch
  p_spacing_restart_r8: assert property (@(posedge clk) disable iff (rst)
    launch |=> !spacing_ok || (CYC_MIN == 1));

endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
  import sar_rd_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CONV_CYC = 550,
  parameter int unsigned EN_CYC   = 15,
  parameter int unsigned SCK_HALF = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic cnv,
  output logic sclk,
  output logic busy,
  output logic idle,
  output logic cap_en,
  output logic cap_last
);
  localparam int unsigned CNT_W = cnt_bits(max3(CONV_CYC, EN_CYC, SCK_HALF));
  localparam int unsigned BIT_W = cnt_bits(DATA_W);
  localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] EN_END   = CNT_W'(EN_CYC - 1);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(SCK_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  rd_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             phase_end;
  logic             last_bit;

  always_comb begin
    case (st_q)
      ST_CONV:          phase_end = (cnt_q == CONV_END);
      ST_ENW:           phase_end = (cnt_q == EN_END);
      ST_SCKH, ST_SCKL: phase_end = (cnt_q == HALF_END);
      default:          phase_end = 1'b0;
    endcase
  end

  assign idle     = (st_q == ST_IDLE);
  assign last_bit = (bit_q == BIT_LAST);
  assign cap_en   = phase_end && ((st_q == ST_ENW) || (st_q == ST_SCKL));
  assign cap_last = phase_end && (st_q == ST_SCKL) && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      cnv   <= 1'b0;
      sclk  <= 1'b0;
      busy  <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      if (launch) begin
        st_q  <= ST_CONV;
        cnt_q <= '0;
        cnv   <= 1'b1;
        busy  <= 1'b1;
      end
    end else if (!phase_end) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q <= '0;
      case (st_q)
        ST_CONV: begin
          cnv  <= 1'b0;
          st_q <= ST_ENW;
        end
        ST_ENW: begin
          sclk  <= 1'b1;
          bit_q <= BIT_W'(1);
          st_q  <= ST_SCKH;
        end
        ST_SCKH: begin
          sclk <= 1'b0;
          st_q <= ST_SCKL;
        end
        ST_SCKL: begin
          if (last_bit) begin
            busy <= 1'b0;
            st_q <= ST_IDLE;
          end else begin
            bit_q <= bit_q + BIT_W'(1);
            sclk  <= 1'b1;
            st_q  <= ST_SCKH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R3: no serial clock while the enable delay runs
  p_enable_wait_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ENW) |-> (!cnv && !sclk));

  // R7: the strobe rises only with busy set
  p_busy_on_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cnv) |-> busy);

endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              cap_en,
  input  logic              cap_last,
  input  logic              sdo,
  output logic [DATA_W-1:0] result,
  output logic              result_valid
);
  logic [DATA_W-2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q         <= '0;
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= cap_last;
      if (clear)       sh_q <= '0;
      else if (cap_en) sh_q <= {sh_q[DATA_W-3:0], sdo};
      if (cap_last)    result <= {sh_q, sdo};
    end
  end

  // R6: one-cycle strobe
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);

  // R6: result moves only with its strobe
  p_result_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));

endmodule

// File: rtl/sar_serial_reader.sv
module sar_serial_reader
  import sar_rd_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CONV_CYC    = 550,
  parameter int unsigned EN_CYC      = 15,
  parameter int unsigned SCK_HALF    = 7,
  parameter int unsigned CYC_MIN     = 1000,
  parameter int unsigned AUTO_PERIOD = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic              auto_en,
  input  logic              adc_sdo,
  output logic              adc_cnv,
  output logic              adc_sclk,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              busy
);
  localparam int unsigned HI_W   = cnt_bits(CONV_CYC + 1);
  localparam int unsigned FALL_W = cnt_bits(DATA_W);

  // named internal events
  logic launch;
  logic spacing_ok;
  logic seq_idle;
  logic cap_en;
  logic cap_last;

  sar_rd_rate #(
    .CYC_MIN    (CYC_MIN),
    .AUTO_PERIOD(AUTO_PERIOD)
  ) u_rate (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .auto_en   (auto_en),
    .seq_idle  (seq_idle),
    .launch    (launch),
    .spacing_ok(spacing_ok)
  );

  sar_rd_seq #(
    .DATA_W  (DATA_W),
    .CONV_CYC(CONV_CYC),
    .EN_CYC  (EN_CYC),
    .SCK_HALF(SCK_HALF)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .cnv     (adc_cnv),
    .sclk    (adc_sclk),
    .busy    (busy),
    .idle    (seq_idle),
    .cap_en  (cap_en),
    .cap_last(cap_last)
  );

  sar_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk         (clk),
    .rst         (rst),
    .clear       (launch),
    .cap_en      (cap_en),
    .cap_last    (cap_last),
    .sdo         (adc_sdo),
    .result      (result),
    .result_valid(result_valid)
  );

  // observation counters for the pin-level properties
  logic [HI_W-1:0]   hi_cnt_q;
  logic [FALL_W-1:0] fall_cnt_q;
  logic              sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q   <= '0;
      fall_cnt_q <= '0;
      sclk_q     <= 1'b0;
    end else begin
      hi_cnt_q <= adc_cnv ? hi_cnt_q + HI_W'(1) : '0;
      sclk_q   <= adc_sclk;
      if (launch)                   fall_cnt_q <= '0;
      else if (sclk_q && !adc_sclk) fall_cnt_q <= fall_cnt_q + FALL_W'(1);
    end
  end

  // R2: strobe width
  p_cnv_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cnv) |-> (hi_cnt_q == HI_W'(CONV_CYC)));

  // R3: clock quiet while converting
  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    adc_cnv |-> !adc_sclk);

  // R4: falling-edge count at completion
  p_fall_count_r4: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (fall_cnt_q == FALL_W'(DATA_W - 1)));

  // R7: busy released with the result strobe
  p_busy_clear_r7: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> !busy);

  // R8: every strobe rise follows a met spacing limit
  p_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_cnv) |-> $past(spacing_ok));

endmodule

// File: tb/tb_sar_serial_reader.sv
module tb_sar_serial_reader;
  localparam int W    = 16;
  localparam int CONV = 40;
  localparam int EN   = 3;
  localparam int HALF = 2;
  localparam int CMIN = 150;
  localparam int APER = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic auto_en = 1'b0;
  logic sdo = 1'b0;
  wire  cnv, sclk, result_valid, busy;
  wire  [W-1:0] result;

  always #2 clk = ~clk;

  sar_serial_reader #(
    .DATA_W(W), .CONV_CYC(CONV), .EN_CYC(EN), .SCK_HALF(HALF),
    .CYC_MIN(CMIN), .AUTO_PERIOD(APER)
  ) dut (
    .clk(clk), .rst(rst), .start_req(start_req), .auto_en(auto_en),
    .adc_sdo(sdo), .adc_cnv(cnv), .adc_sclk(sclk),
    .result(result), .result_valid(result_valid), .busy(busy)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: latch on strobe rise, MSB on strobe fall, shift on sclk fall
  logic [W-1:0] vals [64];
  int           ri = 0;
  logic [W-1:0] word = '0;
  int           idx = 0;

  always @(posedge cnv) begin
    word = vals[ri % 64];
    ri++;
  end
  always @(negedge cnv) begin
    #1;
    idx = W - 1;
    sdo = word[idx];
  end
  always @(negedge sclk) begin
    #3;
    if (idx > 0) idx--;
    sdo = word[idx];
  end

  // pin monitor, sampled mid-cycle
  int cyc = 0, last_rise = 0, hi_w = 0, falls = 0, hrun = 0, en_run = 0;
  int gap_expect = 0, epoch = 0, seen_epoch = 0, nvalid = 0;
  bit have_rise = 0, cnv_q = 0, sclk_q = 0, valid_q = 0, en_armed = 0;
  logic [W-1:0] res_q = '0;

  always @(negedge clk) begin
    if (rst) begin
      have_rise = 0; cnv_q = 0; sclk_q = 0; valid_q = 0; en_armed = 0;
      hi_w = 0; falls = 0; hrun = 0; res_q = result;
    end else begin
      cyc++;
      if (seen_epoch != epoch) begin
        seen_epoch = epoch;
        have_rise = 0;
      end
      if (cnv && !cnv_q) begin
        if (have_rise && gap_expect != 0)
          chk(cyc - last_rise == gap_expect, "R8/R10 rise gap", cyc - last_rise, gap_expect);
        last_rise = cyc; have_rise = 1; hi_w = 0; falls = 0;
      end
      if (cnv) hi_w++;
      if (en_armed) begin
        if (sclk) begin
          chk(en_run == EN, "R3 enable wait", en_run, EN);
          en_armed = 0;
        end else en_run++;
      end
      if (!cnv && cnv_q) begin
        chk(hi_w == CONV, "R2 strobe width", hi_w, CONV);
        en_armed = 1; en_run = 1;
      end
      if (cnv && sclk) chk(0, "R3 sclk during conversion", 1, 0);
      if (sclk) hrun++;
      if (!sclk && sclk_q) begin
        falls++;
        chk(hrun == HALF, "R4 high phase", hrun, HALF);
        hrun = 0;
      end
      if (cnv && !busy) chk(0, "R7 busy during strobe", 0, 1);
      if (result_valid) begin
        chk(result == word, "R5 result word", result, word);
        chk(falls == W - 1, "R4 falling edges", falls, W - 1);
        chk(!busy, "R7 busy at strobe", busy, 0);
        chk(!valid_q, "R6 single-cycle strobe", valid_q, 0);
        nvalid++;
      end else if (result !== res_q) begin
        chk(0, "R6 result stable", result, res_q);
      end
      cnv_q = cnv; sclk_q = sclk; valid_q = result_valid; res_q = result;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_valid(input string tag);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!result_valid && n < 3000);
    if (n >= 3000) chk(0, tag, 0, 1);
  endtask

  task automatic start_checked();
    step(1);
    start_req = 1'b1;
    step(1);
    start_req = 1'b0;
    chk(cnv == 1'b0, "R11 strobe not yet raised", cnv, 0);
    step(1);
    chk(cnv == 1'b1, "R11 strobe raised next edge", cnv, 1);
  endtask

  task automatic check_reset_state(input string tag);
    chk(cnv == 1'b0, tag, cnv, 0);
    chk(sclk == 1'b0, tag, sclk, 0);
    chk(busy == 1'b0, tag, busy, 0);
    chk(result_valid == 1'b0, tag, result_valid, 0);
    chk(result == '0, tag, result, 0);
  endtask

  initial begin
    int base;
    for (int i = 0; i < 64; i++) begin
      if (i < W) vals[i] = W'(1) << i;
      else vals[i] = W'((i * 40503 + 7) & 16'hFFFF);
    end
    vals[16] = 16'h0000; vals[17] = 16'hFFFF; vals[18] = 16'hAAAA;
    vals[19] = 16'h5555; vals[20] = 16'h8001;

    // R1: reset state
    step(4);
    check_reset_state("R1 during reset");
    rst = 1'b0;
    step(1);
    check_reset_state("R1 after release");

    // R5/R11: sweep of single conversions
    for (int i = 0; i < 21; i++) begin
      step(CMIN);
      start_checked();
      wait_valid("R5 conversion timeout");
    end

    // R8/R9: second request while the first conversion runs
    step(CMIN);
    gap_expect = CMIN; epoch++;
    base = nvalid;
    start_req = 1'b1; step(1); start_req = 1'b0;
    step(20);
    start_req = 1'b1; step(1); start_req = 1'b0;
    wait_valid("R9 first timeout");
    step(1);
    wait_valid("R9 second timeout");
    step(CMIN + 50);
    chk(nvalid - base == 2, "R9 exactly one extra conversion", nvalid - base, 2);

    // R10: timer-driven conversions
    gap_expect = APER; epoch++;
    base = nvalid;
    auto_en = 1'b1;
    step(APER * 6);
    auto_en = 1'b0;
    step(APER + CMIN);
    chk(nvalid - base >= 5, "R10 timer conversions", nvalid - base, 5);
    gap_expect = 0; epoch++;

    // R1: reset in the middle of readout
    step(CMIN);
    start_checked();
    step(CONV + 10);
    rst = 1'b1;
    step(1);
    check_reset_state("R1 mid-conversion reset");
    step(2);
    rst = 1'b0;
    step(CMIN);
    start_checked();
    wait_valid("R5 recovery timeout");
    step(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule